// File: doc/BRIEF.md
# Banked GPIO Port Register Block

This block is the general-purpose I/O function of a configuration controller. Its pins are grouped into banks of up to eight. Each bank has a window of four consecutive byte registers in an 8-bit register index space. The main banks have their bases at 0xF0, 0xE0, 0xD0 and so on, stepping down by 0x10. An optional extra bank sits at a base given by a parameter, for example 0x88 or 0x98. Within a bank window, offset 0 holds pin direction, offset 1 holds the output data, offset 2 reports the pin status, and offset 3 selects the output mode.

Software reaches the registers through an index/data byte pair. It first writes an index. Later data-port writes then update the register that index selects. The data-port read value always shows the register at the current index.

Every pin drives its pad through an output enable and an output value. The drive can be push-pull or open-drain, chosen per pin. The pad inputs return to the status register through a two-flop synchronizer. A bank may implement fewer than eight pins. Bits above its pin count read as zero, ignore writes and never drive a pad.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every pin is an input (pad_oe is 0), output data is 0, output mode is open-drain (0), and the direction, data and mode registers of every bank read 0.
- R2: A write on the index port selects a register. Later data-port writes update that register, and dat_rdata shows the selected register's value from the cycle after the index write.
- R3: In a bank with P pins, register bits P to 7 read as 0, ignore writes, and the matching pad_oe and pad_out bits stay 0.
- R4: Main bank b has its base at 0xF0 minus 16*b. The extra bank has its base at EXTRA_BASE. Offsets 0, 1, 2 and 3 select direction, output data, status and output mode. Any other index reads 0, and a data write to it changes no register and no pad.
- R5: A direction bit of 1 makes the pin an output. With a direction bit of 0 the pin's pad_oe is 0, whatever its data or mode bit.
- R6: An output pin with mode bit 1 (push-pull) has pad_oe 1, and pad_out equals its data bit.
- R7: An output pin with mode bit 0 (open-drain) has pad_oe 1 and pad_out 0 when its data bit is 0. When its data bit is 1, pad_oe is 0.
- R8: The status register shows pad_in through two flops, for input and output pins alike. A pad change that is present before clock edge k reads back after edge k+1, and not after edge k alone.
- R9: A data write to a status offset changes no register and no pad.
- R10: The output data register reads back the value last written to it, masked to the implemented pins, whatever the pin's direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_we | input | 1 | Index port write strobe |
| idx_wdata | input | 8 | Register index to select |
| dat_we | input | 1 | Data port write strobe |
| dat_wdata | input | 8 | Data written to the selected register |
| dat_rdata | output | 8 | Value of the selected register |
| pad_in | input | 8*NUM_BANKS | Pad input levels, bank b at bits 8b+7..8b |
| pad_oe | output | 8*NUM_BANKS | Pad output enables |
| pad_out | output | 8*NUM_BANKS | Pad output values |

## Verification
The bench uses the default parameters. These give eight main banks with bases from 0xF0 down to 0x80, plus an extra bank at 0x88. Pin counts are mixed: 6, 8, 8, 8, 8, 5, 8, 7 and 4. The mixed counts exercise the masking of unimplemented bits at several widths. The extra bank at 0x88 sits inside the 16-byte stride of the 0x80 bank, so the bench can probe decoding next to that bank, for example at index 0x84. Random writes across all banks and offsets, together with random pad patterns, cover every mix of direction, mode and data.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int REGS_PER_BANK = 4;
  localparam int BANK_WIDTH    = 8;
  localparam int MAIN_STRIDE   = 16;
  localparam logic [7:0] FIRST_BASE = 8'hF0;

  typedef enum logic [1:0] {
    REG_DIR  = 2'd0,
    REG_OUT  = 2'd1,
    REG_STS  = 2'd2,
    REG_MODE = 2'd3
  } bank_reg_e;

  // Base index of bank idx: main banks step down from FIRST_BASE, the extra bank sits at extra_base.
  function automatic logic [7:0] bank_base(input int idx, input int n_main,
                                           input logic [7:0] extra_base);
    if (idx < n_main) return FIRST_BASE - 8'(idx * MAIN_STRIDE);
    return extra_base;
  endfunction

  function automatic logic [7:0] pin_mask(input int pins);
    logic [7:0] m;
    m = '0;
    for (int i = 0; i < BANK_WIDTH; i++) if (i < pins) m[i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] dir,
  input  logic [WIDTH-1:0] dat,
  input  logic [WIDTH-1:0] mode,
  input  logic [WIDTH-1:0] mask,
  output logic [WIDTH-1:0] oe,
  output logic [WIDTH-1:0] out
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic drive_active;
    // push-pull drives both levels; open-drain only pulls low
    assign drive_active = mode[i] | ~dat[i];
    assign oe[i]  = mask[i] & dir[i] & drive_active;
    assign out[i] = mask[i] & dat[i];
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int         PINS = 8,
  parameter logic [7:0] BASE = 8'hF0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] idx,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic [7:0] sts_in,
  output logic [7:0] rdata,
  output logic [7:0] pad_oe,
  output logic [7:0] pad_out
);

  localparam logic [7:0] MASK = pin_mask(PINS);

  logic       hit;
  bank_reg_e  sel;
  logic       reg_en;
  logic [7:0] dir_q, dir_d;
  logic [7:0] dat_q, dat_d;
  logic [7:0] mode_q, mode_d;

  assign hit    = (idx[7:2] == BASE[7:2]);
  assign sel    = bank_reg_e'(idx[1:0]);
  assign reg_en = wr_en & hit;

  always_comb begin
    dir_d  = dir_q;
    dat_d  = dat_q;
    mode_d = mode_q;
    if (reg_en) begin
      unique case (sel)
        REG_DIR:  dir_d  = wdata & MASK;
        REG_OUT:  dat_d  = wdata & MASK;
        REG_STS:  ;
        REG_MODE: mode_d = wdata & MASK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dat_q  <= '0;
      mode_q <= '0;
    end else if (reg_en) begin
      dir_q  <= dir_d;
      dat_q  <= dat_d;
      mode_q <= mode_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      unique case (sel)
        REG_DIR:  rdata = dir_q;
        REG_OUT:  rdata = dat_q;
        REG_STS:  rdata = sts_in & MASK;
        REG_MODE: rdata = mode_q;
      endcase
    end
  end

  gpio_pad_ctrl #(.WIDTH(8)) u_pad (
    .dir  (dir_q),
    .dat  (dat_q),
    .mode (mode_q),
    .mask (MASK),
    .oe   (pad_oe),
    .out  (pad_out)
  );

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int          NUM_MAIN_BANKS = 8,
  parameter bit          HAS_EXTRA_BANK = 1'b1,
  parameter logic [7:0]  EXTRA_BASE     = 8'h88,
  parameter logic [63:0] BANK_PINS      = 64'h0000_0004_7858_8886,
  parameter int          SYNC_STAGES    = 2,
  localparam int         NUM_BANKS      = NUM_MAIN_BANKS + int'(HAS_EXTRA_BANK),
  localparam int         NUM_PINS       = NUM_BANKS * BANK_WIDTH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                idx_we,
  input  logic [7:0]          idx_wdata,
  input  logic                dat_we,
  input  logic [7:0]          dat_wdata,
  output logic [7:0]          dat_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out
);

  logic [7:0]          idx_q, idx_d;
  logic [NUM_PINS-1:0] pad_sync;
  logic [7:0]          bank_rdata [NUM_BANKS];

  always_comb begin
    idx_d = idx_q;
    if (idx_we) idx_d = idx_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  gpio_pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pad_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int         PINS_B = int'(BANK_PINS[4*b +: 4]);
    localparam logic [7:0] BASE_B = bank_base(b, NUM_MAIN_BANKS, EXTRA_BASE);

    gpio_bank #(.PINS(PINS_B), .BASE(BASE_B)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx     (idx_q),
      .wr_en   (dat_we),
      .wdata   (dat_wdata),
      .sts_in  (pad_sync[b*BANK_WIDTH +: BANK_WIDTH]),
      .rdata   (bank_rdata[b]),
      .pad_oe  (pad_oe[b*BANK_WIDTH +: BANK_WIDTH]),
      .pad_out (pad_out[b*BANK_WIDTH +: BANK_WIDTH])
    );
  end

  // Only one bank decodes a given index, so OR-combining the bank read values is safe.
  always_comb begin
    dat_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) dat_rdata = dat_rdata | bank_rdata[b];
  end

endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk
  import gpio_bank_pkg::*;
#(
  parameter int          NUM_MAIN_BANKS = 8,
  parameter bit          HAS_EXTRA_BANK = 1'b1,
  parameter logic [7:0]  EXTRA_BASE     = 8'h88,
  parameter logic [63:0] BANK_PINS      = 64'h0000_0004_7858_8886,
  localparam int         NUM_BANKS      = NUM_MAIN_BANKS + int'(HAS_EXTRA_BANK),
  localparam int         NUM_PINS       = NUM_BANKS * BANK_WIDTH
) (
  input logic                clk,
  input logic                rst_n,
  input logic                dat_we,
  input logic [7:0]          idx_q,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] pad_out
);

  function automatic logic [NUM_PINS-1:0] impl_mask();
    logic [NUM_PINS-1:0] m;
    m = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      m[b*BANK_WIDTH +: BANK_WIDTH] = pin_mask(int'(BANK_PINS[4*b +: 4]));
    return m;
  endfunction

  function automatic logic is_mapped(input logic [7:0] a);
    logic r;
    r = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      logic [7:0] base;
      base = bank_base(b, NUM_MAIN_BANKS, EXTRA_BASE);
      if (a[7:2] == base[7:2]) r = 1'b1;
    end
    return r;
  endfunction

  localparam logic [NUM_PINS-1:0] IMPL = impl_mask();

  a_r1_reset_all_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0));

  a_r3_unimpl_pads_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ~IMPL) == '0) && ((pad_out & ~IMPL) == '0));

  a_r2_pads_move_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_we |=> ($stable(pad_oe) && $stable(pad_out)));

  a_r9_status_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && idx_q[1:0] == 2'd2) |=> ($stable(pad_oe) && $stable(pad_out)));

  a_r4_unmapped_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && !is_mapped(idx_q)) |=> ($stable(pad_oe) && $stable(pad_out)));

endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(
  .NUM_MAIN_BANKS (NUM_MAIN_BANKS),
  .HAS_EXTRA_BANK (HAS_EXTRA_BANK),
  .EXTRA_BASE     (EXTRA_BASE),
  .BANK_PINS      (BANK_PINS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .dat_we  (dat_we),
  .idx_q   (idx_q),
  .pad_oe  (pad_oe),
  .pad_out (pad_out)
);

// File: tb/gpio_bank_regs_bench.sv
module gpio_bank_regs_bench;

  localparam int          CLK_PERIOD = 10;
  localparam int          NMAIN      = 8;
  localparam bit          HAS_X      = 1'b1;
  localparam logic [7:0]  XBASE      = 8'h88;
  localparam logic [63:0] PINS_CFG   = 64'h0000_0004_7858_8886;
  localparam int          NB         = NMAIN + 1;
  localparam int          NP         = NB * 8;

  logic          clk, rst_n;
  logic          idx_we, dat_we;
  logic [7:0]    idx_wdata, dat_wdata, dat_rdata;
  logic [NP-1:0] pad_in, pad_oe, pad_out;

  gpio_bank_regs #(
    .NUM_MAIN_BANKS (NMAIN),
    .HAS_EXTRA_BANK (HAS_X),
    .EXTRA_BASE     (XBASE),
    .BANK_PINS      (PINS_CFG)
  ) u_gpio_bank_regs (
    .clk (clk), .rst_n (rst_n),
    .idx_we (idx_we), .idx_wdata (idx_wdata),
    .dat_we (dat_we), .dat_wdata (dat_wdata), .dat_rdata (dat_rdata),
    .pad_in (pad_in), .pad_oe (pad_oe), .pad_out (pad_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] m_dir [NB];
  logic [7:0] m_dat [NB];
  logic [7:0] m_mode[NB];

  function automatic logic [7:0] f_base(input int b);
    return (b < NMAIN) ? 8'(8'hF0 - 16*b) : XBASE;
  endfunction

  function automatic logic [7:0] f_mask(input int b);
    int p;
    p = int'(PINS_CFG[4*b +: 4]);
    return 8'((9'd1 << p) - 9'd1);
  endfunction

  function automatic logic [NP-1:0] f_oe();
    logic [NP-1:0] r;
    for (int b = 0; b < NB; b++)
      r[b*8 +: 8] = m_dir[b] & (m_mode[b] | ~m_dat[b]) & f_mask(b);
    return r;
  endfunction

  function automatic logic [NP-1:0] f_out();
    logic [NP-1:0] r;
    for (int b = 0; b < NB; b++) r[b*8 +: 8] = m_dat[b] & f_mask(b);
    return r;
  endfunction

  task automatic chk8(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic chk_pads(input string req);
    n_chk++;
    if (pad_oe !== f_oe() || pad_out !== f_out()) begin
      n_fail++;
      $display("FAIL %s pads: actual oe %h out %h expected oe %h out %h",
               req, pad_oe, pad_out, f_oe(), f_out());
    end
  endtask

  task automatic wr_idx(input logic [7:0] a);
    @(negedge clk); idx_we = 1'b1; idx_wdata = a;
    @(negedge clk); idx_we = 1'b0;
  endtask

  task automatic wr_dat(input logic [7:0] v);
    @(negedge clk); dat_we = 1'b1; dat_wdata = v;
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] v);
    wr_idx(a);
    #1 v = dat_rdata;
  endtask

  // Write through the ports and update the model per the requirements.
  task automatic put(input logic [7:0] a, input logic [7:0] v);
    wr_idx(a);
    wr_dat(v);
    for (int b = 0; b < NB; b++) begin
      if (a[7:2] == f_base(b)) begin
        // exact-base match also needs offset bits clear in the compare below
      end
      if (a[7:2] == f_base(b)[7:2]) begin
        case (a[1:0])
          2'd0: m_dir[b]  = v & f_mask(b);
          2'd1: m_dat[b]  = v & f_mask(b);
          2'd3: m_mode[b] = v & f_mask(b);
          default: ;
        endcase
      end
    end
  endtask

  task automatic chk_all(input string req);
    logic [7:0] v;
    repeat (2) @(negedge clk);
    for (int b = 0; b < NB; b++) begin
      rd_reg(f_base(b) + 8'd0, v); chk8(req, $sformatf("dir bank %0d", b), v, m_dir[b]);
      rd_reg(f_base(b) + 8'd1, v); chk8(req, $sformatf("data bank %0d", b), v, m_dat[b]);
      rd_reg(f_base(b) + 8'd2, v); chk8("R8", $sformatf("status bank %0d", b), v, pad_in[b*8 +: 8] & f_mask(b));
      rd_reg(f_base(b) + 8'd3, v); chk8(req, $sformatf("mode bank %0d", b), v, m_mode[b]);
    end
    chk_pads(req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; idx_we = 1'b0; dat_we = 1'b0;
    idx_wdata = '0; dat_wdata = '0; pad_in = '0;
    for (int b = 0; b < NB; b++) begin m_dir[b] = '0; m_dat[b] = '0; m_mode[b] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    n_chk++;
    if (pad_oe !== '0 || pad_out !== '0) begin
      n_fail++; $display("FAIL R1 reset pads: actual oe %h out %h expected 0", pad_oe, pad_out);
    end
    chk_all("R1");

    // R3 + R7: bank 0 (6 pins), open-drain by default
    put(8'hF0, 8'hFF);
    rd_reg(8'hF0, v); chk8("R3", "dir masked to 6 pins", v, 8'h3F);
    chk_pads("R7");
    put(8'hF1, 8'h15);
    chk8("R7", "bank0 oe open-drain", pad_oe[7:0], 8'h2A);
    chk8("R7", "bank0 out open-drain", pad_out[7:0], 8'h15);
    // R6: push-pull
    put(8'hF3, 8'hFF);
    chk8("R6", "bank0 oe push-pull", pad_oe[7:0], 8'h3F);
    chk8("R6", "bank0 out push-pull", pad_out[7:0], 8'h15);

    // R5: inputs never driven
    put(8'hE1, 8'hFF); put(8'hE3, 8'hFF); put(8'hE0, 8'h0F);
    chk8("R5", "bank1 oe partial outputs", pad_oe[15:8], 8'h0F);
    // R10: data readback independent of direction
    put(8'hE0, 8'h00);
    rd_reg(8'hE1, v); chk8("R10", "bank1 data with inputs", v, 8'hFF);

    // R9: status write ignored
    put(8'hF2, 8'hFF);
    chk_all("R9");

    // R4: unmapped indices and the extra bank at 0x88
    put(8'h00, 8'hFF); put(8'h84, 8'hFF); put(8'hF4, 8'hFF); put(8'h8C, 8'hFF); put(8'h7F, 8'hFF);
    rd_reg(8'h84, v); chk8("R4", "unmapped 0x84 reads 0", v, 8'h00);
    chk_all("R4");
    put(8'h88, 8'hFF);
    rd_reg(8'h88, v); chk8("R4", "extra bank dir (4 pins)", v, 8'h0F);
    rd_reg(8'h80, v); chk8("R4", "bank 0x80 dir untouched", v, m_dir[7]);

    // R8: two-flop latency on the status register
    wr_idx(8'hF2);
    pad_in[7:0] = 8'hAD;
    @(negedge clk); chk8("R8", "status after one edge", dat_rdata, 8'h00);
    @(negedge clk); chk8("R8", "status after two edges", dat_rdata, 8'h2D);

    // R2: random traffic over all banks and offsets
    for (int it = 0; it < 400; it++) begin
      int b;
      logic [7:0] a;
      b = int'($urandom_range(NB - 1));
      a = f_base(b) + 8'($urandom_range(3));
      if ($urandom_range(9) == 0) a = 8'($urandom);
      put(a, 8'($urandom));
      chk_pads("R5");
      if ($urandom_range(3) == 0)
        for (int k = 0; k < NB; k++) pad_in[k*8 +: 8] = 8'($urandom);
      if (it % 16 == 15) chk_all("R2");
    end
    chk_all("R10");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule